// File: doc/BRIEF.md
# Expansion Card Configuration Responder

This block answers the host's plug-and-play probe for a 32-bit expansion card. While the card is unconfigured, it serves a 128-byte configuration window. The window is built from a descriptor vector that is captured at reset. Each descriptor byte is split into two nibbles, and each nibble is placed in the upper half of its own even byte lane. Most nibble entries are stored inverted.

The host assigns the card a location by writing to fixed offsets in the window. A byte write can stage the low byte of the base address. A word write commits the upper half of the base address, marks the card configured and opens a 16 MB decode window. A different byte write instead parks the card in a silent configured state, with no window. When configuration finishes, the block pulses a release toward the next card in the chain.

After configuration, the block stops answering reads of the window and ignores further configuration writes. It then flags any access whose address falls inside the assigned window, so that the board decoder can take it.

Top module: `autocfg_responder`

## Requirements
- R1: After a reset cycle: `configured`=0, `shut_up`=0, `base_addr`=0, `dec_mask`=0x0000FFFF, `rvalid`=0 and `chain_release`=0.
- R2: For offsets of the form 4*i, where i < 32, the read byte has descriptor byte i's high nibble in bits [7:4] and 0 in bits [3:0]. The whole byte is then bitwise inverted, giving {~nibble, 4'hF}.
- R3: For offsets of the form 4*i+2, the read byte holds descriptor byte i's low nibble in bits [7:4], using the same layout and inversion rule as R2.
- R4: The entries at offsets 0x00, 0x02, 0x40 and 0x42 are not inverted: they read as {nibble, 4'h0}.
- R5: Odd offsets below 128 read 0xFF.
- R6: While unconfigured, only address bits [15:0] select the offset. Offsets of 128 or more read 0x00.
- R7: A read strobe while unconfigured raises `rvalid` for exactly one cycle on the next clock edge, with `rdata` valid in that cycle.
- R8: A byte write (`word`=0) to offset 0x48 while unconfigured loads `base_addr[23:16]` from `wdata[7:0]`. It leaves the card unconfigured.
- R9: A word write (`word`=1) to offset 0x44 while unconfigured loads `base_addr[31:16]` from `wdata`. On the next edge it also sets `configured`, sets `dec_mask` to 0x00FFFFFF and pulses `chain_release` high for one cycle.
- R10: A byte write to offset 0x4C while unconfigured sets `configured` and `shut_up` and pulses `chain_release`. It leaves `base_addr` and `dec_mask` unchanged, and `board_sel` then never asserts.
- R11: Once configured, writes to the window offsets change nothing, and read strobes no longer raise `rvalid`.
- R12: When configured and not silent, `board_sel` is high in exactly those cycles that have a read or write strobe and satisfy (addr & ~dec_mask) == base_addr.
- R13: Reset captures `desc_i` again, so a new descriptor appears in the window after the next reset.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| addr | input | ADDR_W | Host address |
| wdata | input | 16 | Write data (byte writes use bits [7:0]) |
| rd | input | 1 | Read strobe |
| wr | input | 1 | Write strobe |
| word | input | 1 | 1 = word access, 0 = byte access |
| desc_i | input | DESC_BYTES*8 | Descriptor bytes, byte i at bits [8i+7:8i], captured at reset |
| rdata | output | 8 | Window read data |
| rvalid | output | 1 | Read data valid |
| configured | output | 1 | Configuration finished |
| shut_up | output | 1 | Card parked without a window |
| chain_release | output | 1 | One-cycle release pulse to the next card |
| base_addr | output | ADDR_W | Assigned base address |
| dec_mask | output | ADDR_W | Address-match mask |
| board_sel | output | 1 | Access falls in the assigned window |

## Verification
The properties assume that `rd` and `wr` are never high in the same cycle. They also assume that `wdata` is only meaningful when `wr` is high. The bench drives every access as a single-cycle strobe on the falling edge and never overlaps a read with a write. The properties check the mask, the release pulse and the base-address stability only relative to `configured` and `shut_up`. They make no claim about the value the host chooses for the base.

// File: rtl/autocfg_responder.sv
module autocfg_responder #(
  parameter int ADDR_W     = 32,
  parameter int DESC_BYTES = 32,
  parameter int AREA       = 128,
  parameter int BASE_LSB   = 16,
  parameter int WIN_BITS   = 24
) (
  input  logic                    clk,
  input  logic                    rst,
  input  logic [ADDR_W-1:0]       addr,
  input  logic [15:0]             wdata,
  input  logic                    rd,
  input  logic                    wr,
  input  logic                    word,
  input  logic [DESC_BYTES*8-1:0] desc_i,
  output logic [7:0]              rdata,
  output logic                    rvalid,
  output logic                    configured,
  output logic                    shut_up,
  output logic                    chain_release,
  output logic [ADDR_W-1:0]       base_addr,
  output logic [ADDR_W-1:0]       dec_mask,
  output logic                    board_sel
);
  localparam int IDX_W = $clog2(DESC_BYTES);
  localparam logic [ADDR_W-1:0] MASK_PRE  = ADDR_W'((64'd1 << 16) - 1);
  localparam logic [ADDR_W-1:0] MASK_POST = ADDR_W'((64'd1 << WIN_BITS) - 1);
  localparam logic [15:0] OFF_COMMIT = 16'h0044;
  localparam logic [15:0] OFF_LOW    = 16'h0048;
  localparam logic [15:0] OFF_PARK   = 16'h004C;

  logic [DESC_BYTES*8-1:0] desc_q;
  logic [15:0]             off;
  logic [IDX_W-1:0]        idx;
  logic [7:0]              dbyte, entry, cfg_byte;
  logic [3:0]              nib;
  logic                    covered, exempt;

  assign off     = addr[15:0];
  assign idx     = off[IDX_W+1:2];
  assign covered = (32'(off[15:2]) < DESC_BYTES);
  assign exempt  = (off == 16'h0000) || (off == 16'h0002) ||
                   (off == 16'h0040) || (off == 16'h0042);
  assign dbyte   = 8'(desc_q >> {idx, 3'b000});
  assign nib     = off[1] ? dbyte[3:0] : dbyte[7:4];
  assign entry   = exempt ? {nib, 4'h0} : ~{nib, 4'h0};

  always_comb begin
    if (32'(off) >= AREA)      cfg_byte = 8'h00;
    else if (off[0] || !covered) cfg_byte = 8'hFF;
    else                         cfg_byte = entry;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      desc_q        <= desc_i;
      configured    <= 1'b0;
      shut_up       <= 1'b0;
      chain_release <= 1'b0;
      base_addr     <= '0;
      dec_mask      <= MASK_PRE;
      rvalid        <= 1'b0;
      rdata         <= 8'h00;
    end else begin
      chain_release <= 1'b0;
      rvalid        <= rd && !configured;
      rdata         <= (rd && !configured) ? cfg_byte : 8'h00;
      if (wr && !configured) begin
        if (word && off == OFF_COMMIT) begin
          base_addr[ADDR_W-1 -: 16] <= wdata;
          configured    <= 1'b1;
          dec_mask      <= MASK_POST;
          chain_release <= 1'b1;
        end else if (!word && off == OFF_LOW) begin
          base_addr[BASE_LSB +: 8] <= wdata[7:0];
        end else if (!word && off == OFF_PARK) begin
          configured    <= 1'b1;
          shut_up       <= 1'b1;
          chain_release <= 1'b1;
        end
      end
    end
  end

  assign board_sel = configured && !shut_up && (rd || wr) &&
                     ((addr & ~dec_mask) == base_addr);
endmodule

// File: rtl/autocfg_responder_chk.sv
module autocfg_responder_chk #(
  parameter int ADDR_W = 32
) (
  input logic              clk,
  input logic              rst,
  input logic              rd,
  input logic              configured,
  input logic              shut_up,
  input logic              chain_release,
  input logic              rvalid,
  input logic [ADDR_W-1:0] base_addr,
  input logic [ADDR_W-1:0] dec_mask,
  input logic              board_sel
);
  // R1
  reset_state_chk: assert property (@(posedge clk) rst |=> (!configured && !shut_up && base_addr == '0));
  // R7
  rvalid_src_chk: assert property (@(posedge clk) disable iff (rst) rvalid |-> ($past(rd) && !$past(configured)));
  // R9
  release_pulse_chk: assert property (@(posedge clk) disable iff (rst) $rose(configured) |-> chain_release);
  // R9
  release_once_chk: assert property (@(posedge clk) disable iff (rst) chain_release |=> !chain_release);
  // R9
  wide_mask_chk: assert property (@(posedge clk) disable iff (rst) (configured && !shut_up) |-> (dec_mask == ADDR_W'(32'h00FFFFFF)));
  // R10
  silent_chk: assert property (@(posedge clk) disable iff (rst) shut_up |-> (!board_sel && dec_mask == ADDR_W'(32'h0000FFFF)));
  // R11
  frozen_base_chk: assert property (@(posedge clk) disable iff (rst) (configured && $past(configured)) |-> $stable(base_addr));
endmodule

bind autocfg_responder autocfg_responder_chk #(.ADDR_W(ADDR_W)) u_chk (
  .clk(clk), .rst(rst), .rd(rd), .configured(configured), .shut_up(shut_up),
  .chain_release(chain_release), .rvalid(rvalid), .base_addr(base_addr),
  .dec_mask(dec_mask), .board_sel(board_sel)
);

// File: tb/autocfg_responder_test.sv
`timescale 1ns/1ps
module autocfg_responder_test;
  logic         clk = 0;
  logic         rst = 1;
  logic [31:0]  addr = 0;
  logic [15:0]  wdata = 0;
  logic         rd = 0, wr = 0, word = 0;
  logic [255:0] desc_i;
  logic [7:0]   rdata;
  logic         rvalid, configured, shut_up, chain_release, board_sel;
  logic [31:0]  base_addr, dec_mask;

  int total = 0, bad = 0;
  logic [7:0]  exp_q[$];
  string       tag_q[$];
  logic        done = 0;

  always #2.5 clk = ~clk;

  autocfg_responder uut (
    .clk(clk), .rst(rst), .addr(addr), .wdata(wdata), .rd(rd), .wr(wr), .word(word),
    .desc_i(desc_i), .rdata(rdata), .rvalid(rvalid), .configured(configured),
    .shut_up(shut_up), .chain_release(chain_release), .base_addr(base_addr),
    .dec_mask(dec_mask), .board_sel(board_sel)
  );

  function automatic logic [255:0] make_desc(input int mul, input int add);
    logic [255:0] d;
    for (int i = 0; i < 32; i++) d[8*i +: 8] = 8'((i * mul + add) & 255);
    return d;
  endfunction

  function automatic logic [7:0] model(input logic [255:0] d, input logic [15:0] off);
    logic [7:0] b, v;
    logic [3:0] n;
    if (off >= 16'd128) return 8'h00;
    if (off[0]) return 8'hFF;
    b = d[8*off[6:2] +: 8];
    n = off[1] ? b[3:0] : b[7:4];
    v = {n, 4'h0};
    if (off == 16'h0 || off == 16'h2 || off == 16'h40 || off == 16'h42) return v;
    return ~v;
  endfunction

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic do_read(input logic [31:0] a, input string req);
    @(negedge clk);
    addr = a; rd = 1;
    exp_q.push_back(model(desc_i, a[15:0]));
    tag_q.push_back(req);
    @(negedge clk);
    rd = 0;
  endtask

  task automatic do_write(input logic [31:0] a, input logic [15:0] d, input logic w);
    @(negedge clk);
    addr = a; wdata = d; word = w; wr = 1;
    @(negedge clk);
    wr = 0; word = 0;
  endtask

  task automatic do_reset();
    @(negedge clk);
    rst = 1;
    @(negedge clk);
    rst = 0;
  endtask

  always @(negedge clk) begin
    if (!rst && rvalid) begin
      if (exp_q.size() == 0) check("R7 unexpected rvalid", 1, 0);
      else begin
        logic [7:0] e;
        string t;
        e = exp_q.pop_front();
        t = tag_q.pop_front();
        check(t, {24'h0, rdata}, {24'h0, e});
      end
    end
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      total++; bad++;
      $display("FAIL watchdog (all requirements) actual=timeout expected=finish");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    desc_i = make_desc(37, 5);
    repeat (2) @(negedge clk);
    rst = 0;
    // R1
    check("R1 configured", {31'h0, configured}, 0);
    check("R1 shut_up", {31'h0, shut_up}, 0);
    check("R1 base", base_addr, 0);
    check("R1 mask", dec_mask, 32'h0000FFFF);
    check("R1 rvalid", {31'h0, rvalid}, 0);
    check("R1 chain", {31'h0, chain_release}, 0);
    // R2 R3 R4 R5
    for (int o = 0; o < 128; o++) do_read(32'(o), "R2_R3_R4_R5 window byte");
    do_read(32'h0, "R4 offset 0x00");
    do_read(32'h42, "R4 offset 0x42");
    // R6
    do_read(32'h1234_0008, "R6 upper bits ignored");
    do_read(32'h80, "R6 beyond area");
    do_read(32'hFFFF, "R6 top offset");
    // R7: one cycle only
    @(negedge clk);
    check("R7 rvalid drops", {31'h0, rvalid}, 0);
    check("R7 queue drained", exp_q.size(), 0);
    // R8
    do_write(32'h48, 16'h00A5, 0);
    check("R8 low byte", base_addr, 32'h00A5_0000);
    check("R8 still unconfigured", {31'h0, configured}, 0);
    // R9 word write with byte flag at 0x44 ignored
    do_write(32'h44, 16'h1111, 0);
    check("R9 byte at 0x44 ignored", {31'h0, configured}, 0);
    @(negedge clk);
    addr = 32'h0044; wdata = 16'h4000; word = 1; wr = 1;
    @(negedge clk);
    wr = 0; word = 0;
    check("R9 configured", {31'h0, configured}, 1);
    check("R9 base", base_addr, 32'h4000_0000);
    check("R9 mask", dec_mask, 32'h00FFFFFF);
    check("R9 release pulse", {31'h0, chain_release}, 1);
    @(negedge clk);
    check("R9 release ends", {31'h0, chain_release}, 0);
    // R11
    do_write(32'h48, 16'h005A, 0);
    check("R11 low byte ignored", base_addr, 32'h4000_0000);
    do_write(32'h44, 16'h7777, 1);
    check("R11 commit ignored", base_addr, 32'h4000_0000);
    @(negedge clk);
    addr = 32'h0; rd = 1;
    @(negedge clk);
    rd = 0;
    check("R11 no read answer", {31'h0, rvalid}, 0);
    // R12
    @(negedge clk);
    addr = 32'h4012_3456; rd = 1; #1;
    check("R12 hit", {31'h0, board_sel}, 1);
    addr = 32'h4100_0000; #1;
    check("R12 miss", {31'h0, board_sel}, 0);
    rd = 0; addr = 32'h40FF_FFFF; #1;
    check("R12 no strobe", {31'h0, board_sel}, 0);
    wr = 1; #1;
    check("R12 write hit", {31'h0, board_sel}, 1);
    wr = 0;
    // R13
    desc_i = make_desc(11, 163);
    do_reset();
    do_read(32'h10, "R13 new descriptor");
    do_read(32'h12, "R13 new descriptor low");
    do_read(32'h40, "R13 exempt");
    // R10
    do_write(32'h4C, 16'h0000, 0);
    check("R10 configured", {31'h0, configured}, 1);
    check("R10 shut_up", {31'h0, shut_up}, 1);
    check("R10 release", {31'h0, chain_release}, 1);
    check("R10 base", base_addr, 0);
    check("R10 mask", dec_mask, 32'h0000FFFF);
    @(negedge clk);
    addr = 32'h0000_1234; rd = 1; #1;
    check("R10 no select", {31'h0, board_sel}, 0);
    @(negedge clk);
    rd = 0;
    repeat (2) @(negedge clk);
    check("R7 queue empty at end", exp_q.size(), 0);
    done = 1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule